// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a 32-bit in-order core and decides, once per instruction, where the next fetch starts. It decodes only the 6-bit major opcode in bits 31:26 of the instruction word. It then picks one of four next-address sources:
- the sequential address;
- a PC-relative target with a 16-bit word offset;
- a PC-relative target with a 26-bit word offset;
- a register value.

The conditional forms compare the two source register values. The comparison can be an equality test, a signed ordering or an unsigned ordering.

The surrounding pipeline presents the instruction word and the two source operand values. The first operand is the register named by bits 25:21 and the second is the one named by bits 20:16. The pipeline pulses `step_i` when the instruction retires. The unit reports whether control flow leaves the sequential path. For the two call forms it also raises a write request that carries a fixed link register index and the return address PC+4. That request is qualified by the step strobe, so the register file can accept it in the same cycle the PC moves.

The return forms are register jumps through index 29, 30 or 31, and they need no special path. The register file supplies the saved address as the first operand, and the unit clears its two low bits like any other register target. Exception entry and instruction fetch lie outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: Two clock edges after the asynchronous active-low reset is released, `pc_o` equals RESET_VEC with its two low bits cleared (default 0x0000_0100). `taken_o` and `link_we_o` are 0 for an all-zero instruction word.
- R2: While `step_i` is 0, `pc_o` keeps its value and `link_we_o` stays 0, whatever the instruction and operands are.
- R3: When `step_i` is 1 and the opcode (bits 31:26) is none of 17, 18, 19, 20, 21, 23, 48, 54, 56 or 62, `taken_o` is 0 and the next `pc_o` is `pc_o`+4.
- R4: Opcode 17 is taken when the two operands are equal, and opcode 23 is taken when they differ.
- R5: Opcode 18 is taken when the first operand is greater than the second as two's-complement numbers. Opcode 19 is taken when it is greater or equal.
- R6: Opcode 21 is taken when the first operand is greater than the second as unsigned numbers. Opcode 20 is taken when it is greater or equal.
- R7: A taken conditional branch loads `pc_o` + 4 × sign-extended bits 15:0. A conditional branch that is not taken loads `pc_o`+4.
- R8: Opcode 56 is always taken and loads `pc_o` + 4 × sign-extended bits 25:0.
- R9: Opcode 48 is always taken and loads the first operand with bits 1:0 cleared. This covers the return forms whose bits 25:21 hold 29, 30 or 31.
- R10: Opcode 54 jumps as in R9 and opcode 62 jumps as in R8. With `step_i` at 1 both raise `link_we_o`, with `link_idx_o` = 29 and `link_data_o` = `pc_o`+4.
- R11: For every opcode other than 54 and 62, `link_we_o` is 0.
- R12: Bits 1:0 of `pc_o` are 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Retire strobe; the PC advances on this cycle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 32 | Value of the register named by bits 25:21 |
| opb_i | input | 32 | Value of the register named by bits 20:16 |
| pc_o | output | 32 | Current program counter |
| taken_o | output | 1 | The current instruction leaves the sequential path |
| link_we_o | output | 1 | Return-address write request |
| link_idx_o | output | 5 | Register index for the return address |
| link_data_o | output | 32 | Return address (PC+4) |

## Verification
All 64 opcodes are swept against six operand pairs:
- Equal values and the two orders of a small positive pair show whether equality and strict ordering are decoded correctly.
- The pairs 0xFFFF_FFFF/1 and 0x8000_0000/0x7FFF_FFFF take opposite outcomes under signed and unsigned ordering. Between them they expose a swapped signedness in any of the four ordered conditions.

The offset fields cycle through small positive values, small negative values and the most positive and most negative values. That separates a wrong sign extension, a missing ×4 scale or the wrong field width. Register jumps use operands with nonzero low bits, and explicit return forms through indices 29, 30 and 31 show that the alignment mask is applied. Cycles with the strobe low, holding a call or a taken branch, show that neither the PC nor the link request moves.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int INSN_W  = 32;
  localparam int OPC_W   = 6;
  localparam int OPC_LSB = 26;
  localparam int IDX_W   = 5;
  localparam int OFS_S_W = 16;
  localparam int OFS_L_W = 26;

  localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd17;
  localparam logic [OPC_W-1:0] OPC_BR_GTS  = 6'd18;
  localparam logic [OPC_W-1:0] OPC_BR_GES  = 6'd19;
  localparam logic [OPC_W-1:0] OPC_BR_GEU  = 6'd20;
  localparam logic [OPC_W-1:0] OPC_BR_GTU  = 6'd21;
  localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd23;
  localparam logic [OPC_W-1:0] OPC_JMP_REG = 6'd48;
  localparam logic [OPC_W-1:0] OPC_CALL_RG = 6'd54;
  localparam logic [OPC_W-1:0] OPC_JMP_REL = 6'd56;
  localparam logic [OPC_W-1:0] OPC_CALL_RL = 6'd62;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_COND,
    FLOW_REG,
    FLOW_REL
  } flow_e;

  typedef enum logic [2:0] {
    CMP_NONE,
    CMP_EQ,
    CMP_NE,
    CMP_GT_S,
    CMP_GE_S,
    CMP_GT_U,
    CMP_GE_U
  } cmp_e;

  typedef struct packed {
    flow_e kind;
    cmp_e  cmp;
    logic  call;
  } flow_dec_t;

endpackage

// File: rtl/pcs_rstsync.sv
module pcs_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output flow_dec_t        dec
);

  always_comb begin
    dec.kind = FLOW_SEQ;
    dec.cmp  = CMP_NONE;
    dec.call = 1'b0;
    case (opc)
      OPC_BR_EQ:   begin dec.kind = FLOW_COND; dec.cmp = CMP_EQ;   end
      OPC_BR_NE:   begin dec.kind = FLOW_COND; dec.cmp = CMP_NE;   end
      OPC_BR_GTS:  begin dec.kind = FLOW_COND; dec.cmp = CMP_GT_S; end
      OPC_BR_GES:  begin dec.kind = FLOW_COND; dec.cmp = CMP_GE_S; end
      OPC_BR_GTU:  begin dec.kind = FLOW_COND; dec.cmp = CMP_GT_U; end
      OPC_BR_GEU:  begin dec.kind = FLOW_COND; dec.cmp = CMP_GE_U; end
      OPC_JMP_REG: begin dec.kind = FLOW_REG;  end
      OPC_CALL_RG: begin dec.kind = FLOW_REG;  dec.call = 1'b1; end
      OPC_JMP_REL: begin dec.kind = FLOW_REL;  end
      OPC_CALL_RL: begin dec.kind = FLOW_REL;  dec.call = 1'b1; end
      default:     begin dec.kind = FLOW_SEQ;  end
    endcase
  end

endmodule

// File: rtl/pcs_cond.sv
module pcs_cond
  import pcs_pkg::*;
#(
  parameter int W          = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  cmp_e         sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         hit
);

  logic is_eq;
  logic is_lt_u;
  logic is_lt_s;

  generate
    if (SHARED_SUB) begin : g_shared
      // One subtractor yields all three relations.
      logic [W:0] diff;
      assign diff    = {1'b0, opa} - {1'b0, opb};
      assign is_eq   = (diff[W-1:0] == '0);
      assign is_lt_u = diff[W];
      assign is_lt_s = (opa[W-1] ^ opb[W-1]) ? opa[W-1] : diff[W];
    end else begin : g_direct
      assign is_eq   = (opa == opb);
      assign is_lt_u = (opa < opb);
      assign is_lt_s = ($signed(opa) < $signed(opb));
    end
  endgenerate

  always_comb begin
    case (sel)
      CMP_EQ:   hit = is_eq;
      CMP_NE:   hit = !is_eq;
      CMP_GT_S: hit = !is_lt_s && !is_eq;
      CMP_GE_S: hit = !is_lt_s;
      CMP_GT_U: hit = !is_lt_u && !is_eq;
      CMP_GE_U: hit = !is_lt_u;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcs_target.sv
module pcs_target
  import pcs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      pc,
  input  logic [INSN_W-1:0] insn,
  input  logic [W-1:0]      opa,
  output logic [W-1:0]      seq_tgt,
  output logic [W-1:0]      rel_s_tgt,
  output logic [W-1:0]      rel_l_tgt,
  output logic [W-1:0]      reg_tgt
);

  localparam int EXT_S = W - OFS_S_W - 2;
  localparam int EXT_L = W - OFS_L_W - 2;
  localparam logic [W-1:0] ALIGN_MASK = ~{{(W-2){1'b0}}, 2'b11};
  localparam logic [W-1:0] WORD_STEP  = {{(W-3){1'b0}}, 3'b100};

  logic [W-1:0] ofs_s;
  logic [W-1:0] ofs_l;
  logic         unused_bits;

  assign ofs_s = {{EXT_S{insn[OFS_S_W-1]}}, insn[OFS_S_W-1:0], 2'b00};
  assign ofs_l = {{EXT_L{insn[OFS_L_W-1]}}, insn[OFS_L_W-1:0], 2'b00};

  assign seq_tgt   = pc + WORD_STEP;
  assign rel_s_tgt = pc + ofs_s;
  assign rel_l_tgt = pc + ofs_l;
  assign reg_tgt   = opa & ALIGN_MASK;

  // Opcode bits are decoded elsewhere.
  assign unused_bits = ^insn[INSN_W-1:OFS_L_W];

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter logic [31:0] RESET_VEC   = 32'h0000_0100,
  parameter int          LINK_IDX    = 29,
  parameter bit          SHARED_SUB  = 1'b1,
  parameter int          SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [4:0]      link_idx_o,
  output logic [XLEN-1:0] link_data_o
);

  localparam logic [XLEN-1:0] RST_PC = XLEN'(RESET_VEC) & ~XLEN'(3);

  logic            rst_sync_n;
  flow_dec_t       dec;
  logic            cond_hit;
  logic [XLEN-1:0] seq_tgt;
  logic [XLEN-1:0] rel_s_tgt;
  logic [XLEN-1:0] rel_l_tgt;
  logic [XLEN-1:0] reg_tgt;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] next_pc;
  logic            taken;

  pcs_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcs_decode u_dec (
    .opc (insn_i[INSN_W-1:OPC_LSB]),
    .dec (dec)
  );

  pcs_cond #(.W(XLEN), .SHARED_SUB(SHARED_SUB)) u_cond (
    .sel (dec.cmp),
    .opa (opa_i),
    .opb (opb_i),
    .hit (cond_hit)
  );

  pcs_target #(.W(XLEN)) u_tgt (
    .pc        (pc_q),
    .insn      (insn_i),
    .opa       (opa_i),
    .seq_tgt   (seq_tgt),
    .rel_s_tgt (rel_s_tgt),
    .rel_l_tgt (rel_l_tgt),
    .reg_tgt   (reg_tgt)
  );

  // Next-address selection.
  always_comb begin
    taken   = 1'b0;
    next_pc = seq_tgt;
    case (dec.kind)
      FLOW_COND: begin
        taken   = cond_hit;
        next_pc = cond_hit ? rel_s_tgt : seq_tgt;
      end
      FLOW_REG: begin
        taken   = 1'b1;
        next_pc = reg_tgt;
      end
      FLOW_REL: begin
        taken   = 1'b1;
        next_pc = rel_l_tgt;
      end
      default: begin
        taken   = 1'b0;
        next_pc = seq_tgt;
      end
    endcase
  end

  always_comb begin
    pc_d = pc_q;
    if (step_i) begin
      pc_d = next_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= RST_PC;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o        = pc_q;
  assign taken_o     = taken;
  assign link_we_o   = step_i & dec.call;
  assign link_idx_o  = 5'(LINK_IDX);
  assign link_data_o = seq_tgt;

  // R12: the PC is always word aligned.
  a_r12_pc_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_o[1:0] == 2'b00);

  // R2: without the strobe the PC holds.
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_i |=> $stable(pc_o));

  // R3/R7: a step that is not taken advances by one word.
  a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !taken_o) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  // R10: a link request names the fixed register and carries the return address.
  a_r10_link_fields: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_we_o |-> (link_idx_o == 5'(LINK_IDX) && link_data_o == pc_o + XLEN'(4)));

  // R10: every call leaves the sequential path.
  a_r10_call_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_we_o |-> taken_o);

  // R2: the link request is qualified by the strobe.
  a_r2_link_needs_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_we_o |-> step_i);

  // R9/R10: after a taken register jump the PC equals the aligned operand.
  a_r9_reg_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && dec.kind == FLOW_REG) |=> (pc_o == ($past(opa_i) & ~XLEN'(3))));

endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [31:0] insn_i;
  logic [31:0] opa_i;
  logic [31:0] opb_i;
  logic [31:0] pc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_data_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mpc;

  always #5 clk = ~clk;

  pc_sequencer dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .insn_i      (insn_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .pc_o        (pc_o),
    .taken_o     (taken_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_data_o (link_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'd17, 6'd23: return "R4";
      6'd18, 6'd19: return "R5";
      6'd20, 6'd21: return "R6";
      6'd48:        return "R9";
      6'd56:        return "R8";
      6'd54, 6'd62: return "R10";
      default:      return "R3";
    endcase
  endfunction

  // Reference behaviour from the requirements.
  task automatic model(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] pc, output bit tk, output bit call,
                       output logic [31:0] nxt);
    logic [5:0]  op;
    logic [31:0] rs;
    logic [31:0] rl;
    op   = insn[31:26];
    rs   = pc + ({{16{insn[15]}}, insn[15:0]} * 32'd4);
    rl   = pc + ({{6{insn[25]}}, insn[25:0]} * 32'd4);
    call = (op == 6'd54) || (op == 6'd62);
    tk   = 1'b0;
    case (op)
      6'd17: tk = (a == b);
      6'd23: tk = (a != b);
      6'd18: tk = ($signed(a) > $signed(b));
      6'd19: tk = ($signed(a) >= $signed(b));
      6'd21: tk = (a > b);
      6'd20: tk = (a >= b);
      6'd48, 6'd54, 6'd56, 6'd62: tk = 1'b1;
      default: tk = 1'b0;
    endcase
    if (op == 6'd48 || op == 6'd54)      nxt = {a[31:2], 2'b00};
    else if (op == 6'd56 || op == 6'd62) nxt = rl;
    else if (tk)                         nxt = rs;
    else                                 nxt = pc + 32'd4;
  endtask

  task automatic do_step(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b);
    bit          tk;
    bit          call;
    logic [31:0] nxt;
    string       t;
    model(insn, a, b, mpc, tk, call, nxt);
    t = tag_of(insn[31:26]);
    @(negedge clk);
    insn_i = insn; opa_i = a; opb_i = b; step_i = 1'b1;
    #2;
    chk(taken_o == tk, t, {31'd0, taken_o}, {31'd0, tk});
    chk(link_we_o == call, call ? "R10" : "R11", {31'd0, link_we_o}, {31'd0, call});
    if (call) begin
      chk(link_idx_o == 5'd29, "R10", {27'd0, link_idx_o}, 32'd29);
      chk(link_data_o == mpc + 32'd4, "R10", link_data_o, mpc + 32'd4);
    end
    @(posedge clk);
    #1;
    chk(pc_o == nxt, (t == "R3" || t == "R8" || t == "R9" || t == "R10") ? t : "R7", pc_o, nxt);
    chk(pc_o[1:0] == 2'b00, "R12", pc_o, {pc_o[31:2], 2'b00});
    mpc = nxt;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    logic [15:0] o16 [4];
    pa[0] = 32'd5;        pb[0] = 32'd5;
    pa[1] = 32'd5;        pb[1] = 32'd7;
    pa[2] = 32'd7;        pb[2] = 32'd5;
    pa[3] = 32'hFFFF_FFFF; pb[3] = 32'd1;
    pa[4] = 32'd1;        pb[4] = 32'hFFFF_FFFF;
    pa[5] = 32'h8000_0000; pb[5] = 32'h7FFF_FFFF;
    o16[0] = 16'h0010; o16[1] = 16'hFFF0; o16[2] = 16'h7FFF; o16[3] = 16'h8000;

    rst_n = 1'b0; step_i = 1'b0; insn_i = '0; opa_i = '0; opb_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(pc_o == 32'h0000_0100, "R1", pc_o, 32'h0000_0100);
    chk(taken_o == 1'b0, "R1", {31'd0, taken_o}, 32'd0);
    chk(link_we_o == 1'b0, "R1", {31'd0, link_we_o}, 32'd0);
    mpc = 32'h0000_0100;

    // R2: strobe low, call and taken branch presented
    begin
      logic [31:0] held;
      held = pc_o;
      insn_i = {6'd62, 26'h0000_040}; opa_i = 32'h0000_4000;
      #1;
      chk(link_we_o == 1'b0, "R2", {31'd0, link_we_o}, 32'd0);
      repeat (2) @(posedge clk);
      #1;
      chk(pc_o == held, "R2", pc_o, held);
      @(negedge clk);
      insn_i = {6'd17, 10'd0, 16'h0100}; opa_i = 32'd9; opb_i = 32'd9;
      @(posedge clk);
      #1;
      chk(pc_o == held, "R2", pc_o, held);
    end

    // Sweep of every opcode against the operand pairs and offsets
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] ins;
        ins = {op[5:0], 5'd3, 5'd4, o16[(op + k) % 4]};
        if (op == 56 || op == 62) ins[25:16] = (k % 2 == 1) ? 10'h3FF : 10'h000;
        do_step(ins, pa[k] | ((op == 48 || op == 54) ? 32'd3 : 32'd0), pb[k]);
      end
    end

    // R9: return forms through the three fixed link indices
    do_step({6'd48, 5'd29, 5'd0, 16'd0}, 32'h0000_2003, 32'd0);
    do_step({6'd48, 5'd30, 5'd0, 16'd0}, 32'h0000_3001, 32'd0);
    do_step({6'd48, 5'd31, 5'd0, 16'd0}, 32'h0000_4002, 32'd0);

    // R10: call pair with known targets
    do_step({6'd54, 5'd5, 21'd0}, 32'h0000_8000, 32'd0);
    do_step({6'd62, 26'h3FF_FFFF}, 32'd0, 32'd0);

    @(negedge clk);
    step_i = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule